// File: doc/BRIEF.md
# Two-Cycle Fused-Pair Issue Queue

This block is an out-of-order issue queue whose entries each hold one scheduling unit. A unit is either a single instruction or a fused pair of two instructions. Wakeup and select are split across two pipeline stages, so the scheduler cannot issue a single instruction and its dependent on consecutive cycles. A fused pair is selected once and broadcasts its destination tag once. Its dual payload then sends the head and the tail on two consecutive cycles, so a dependent pair still executes back to back even though the scheduling loop is two cycles long.

The front end inserts one unit per cycle. The insert carries up to three source tags, each with a flag that says whether that source is still waiting, plus a destination tag and one or two payloads. The queue selects at most one ready unit per cycle, and the oldest ready unit wins. Each issue cycle emits one payload, and a registered tag broadcast wakes the waiting consumers. A flush empties the queue and abandons any fused pair that is halfway through issue.

Top module: `mop_issue_queue`

## Requirements
- R1: After reset `iss_valid` and `bc_valid` are 0 and `ins_ready` is 1.
- R2: A unit inserted with no waiting source in cycle c issues its head payload in cycle c+2. A single unit broadcasts its destination tag in the same cycle as its issue.
- R3: A unit with waiting sources does not issue until a broadcast has matched every one of its waiting source tags.
- R4: A single unit that depends on a single producer issues two cycles after the producer, never one cycle after it.
- R5: A fused unit (`ins_fused`=1) issues its head payload in cycle T with `iss_second`=0 and its tail payload in T+1 with `iss_second`=1. Its destination tag is broadcast only in T+1.
- R6: A unit that waits on a fused unit's tag issues two cycles after that unit's tail.
- R7: Each issued unit produces exactly one broadcast of its destination tag, whether it is single or fused.
- R8: When several units become ready in the same cycle, the one inserted earliest issues first.
- R9: While a fused unit is sending its tail, no new unit is selected. A unit that was ready behind a fused head issues two cycles after that head.
- R10: When `WIRED_OR`=1 (the default) an entry tracks three source tags and all three must be satisfied. When it is 0 the entry tracks two.
- R11: When `DEPTH` units are held, `ins_ready` is 0 and an insert request is dropped: it never issues.
- R12: When `flush` is high at a clock edge, the queue is empty afterwards. Outputs are idle in the next cycle, a pending tail is never issued and its tag is never broadcast.
- R13: A broadcast in the same cycle as the insert of a unit that waits on that tag clears the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clears all entries and any pending tail |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | Queue has a free entry |
| ins_fused | input | 1 | Unit is a fused pair |
| ins_src_wait | input | NSRC | Per source: 1 means the source is still waiting on its tag |
| ins_src_tag | input | NSRC*TAG_W | Source tags, source 0 in the low bits |
| ins_dst_tag | input | TAG_W | Destination tag of the unit |
| ins_head_pay | input | PAY_W | Payload of the single instruction or of the head |
| ins_tail_pay | input | PAY_W | Payload of the tail (used only if fused) |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_second | output | 1 | The issued instruction is a fused tail |
| iss_pay | output | PAY_W | Issued payload |
| bc_valid | output | 1 | Tag broadcast valid |
| bc_tag | output | TAG_W | Broadcast destination tag |

## Verification
The bench targets the spacing between issues.
- A scheduler with a one-stage loop would issue a dependent single one cycle after its producer.
- One that broadcasts a fused tag with the head would wake the consumer a cycle early.
- One that keeps selecting behind a fused head would place a new payload in the tail's slot.

The bench also probes the following cases:
- Ordering among units that wake in the same cycle.
- A wakeup broadcast that lands on the insert cycle, where a missed match strands the unit.
- A third source that is ignored, which lets a unit issue too early.
- A full queue that accepts an extra insert.
- A flush that lets a half-issued pair finish its tail.

// File: rtl/mop_issue_queue.sv
module mop_issue_queue #(
  parameter int DEPTH = 32,
  parameter int TAG_W = 6,
  parameter int PAY_W = 16,
  parameter bit WIRED_OR = 1'b1,
  localparam int NSRC = WIRED_OR ? 3 : 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  ins_valid,
  output logic                  ins_ready,
  input  logic                  ins_fused,
  input  logic [NSRC-1:0]       ins_src_wait,
  input  logic [NSRC*TAG_W-1:0] ins_src_tag,
  input  logic [TAG_W-1:0]      ins_dst_tag,
  input  logic [PAY_W-1:0]      ins_head_pay,
  input  logic [PAY_W-1:0]      ins_tail_pay,
  output logic                  iss_valid,
  output logic                  iss_second,
  output logic [PAY_W-1:0]      iss_pay,
  output logic                  bc_valid,
  output logic [TAG_W-1:0]      bc_tag
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NSRC-1:0]  wait_q [DEPTH];
  logic [NSRC-1:0]  wait_d [DEPTH];
  logic [TAG_W-1:0] src_q  [DEPTH][NSRC];
  logic [TAG_W-1:0] src_d  [DEPTH][NSRC];
  logic [TAG_W-1:0] dst_q  [DEPTH];
  logic [TAG_W-1:0] dst_d  [DEPTH];
  logic [PAY_W-1:0] hp_q   [DEPTH];
  logic [PAY_W-1:0] hp_d   [DEPTH];
  logic [PAY_W-1:0] tp_q   [DEPTH];
  logic [PAY_W-1:0] tp_d   [DEPTH];
  logic [DEPTH-1:0] fus_q, fus_d;

  logic             tail_pend_q;
  logic [PAY_W-1:0] tail_pay_q;
  logic [TAG_W-1:0] tail_tag_q;

  logic [DEPTH-1:0] rdy;
  logic             sel_any, sel_hit, ins_fire;
  logic [IDX_W-1:0] sel_idx;

  assign ins_ready = (cnt_q != CNT_W'(DEPTH));
  assign ins_fire  = ins_valid && ins_ready && !flush;
  assign sel_hit   = sel_any && !tail_pend_q;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      rdy[i] = (CNT_W'(i) < cnt_q) && (wait_q[i] == '0);
  end

  always_comb begin
    sel_any = 1'b0;
    sel_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (rdy[i]) begin
        sel_any = 1'b1;
        sel_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    logic             shift;
    logic [IDX_W-1:0] k;
    logic [IDX_W-1:0] ipos;
    for (int i = 0; i < DEPTH; i++) begin
      shift = sel_hit && (IDX_W'(i) >= sel_idx);
      k = shift ? IDX_W'(i + 1) : IDX_W'(i);
      if (shift && i == DEPTH - 1) begin
        wait_d[i] = '0;
        dst_d[i]  = '0;
        hp_d[i]   = '0;
        tp_d[i]   = '0;
        fus_d[i]  = 1'b0;
        for (int s = 0; s < NSRC; s++) src_d[i][s] = '0;
      end else begin
        dst_d[i] = dst_q[k];
        hp_d[i]  = hp_q[k];
        tp_d[i]  = tp_q[k];
        fus_d[i] = fus_q[k];
        for (int s = 0; s < NSRC; s++) begin
          src_d[i][s]  = src_q[k][s];
          wait_d[i][s] = wait_q[k][s] && !(bc_valid && bc_tag == src_q[k][s]);
        end
      end
    end
    ipos = IDX_W'(cnt_q - CNT_W'(sel_hit));
    if (ins_fire) begin
      dst_d[ipos] = ins_dst_tag;
      hp_d[ipos]  = ins_head_pay;
      tp_d[ipos]  = ins_tail_pay;
      fus_d[ipos] = ins_fused;
      for (int s = 0; s < NSRC; s++) begin
        src_d[ipos][s]  = ins_src_tag[s*TAG_W +: TAG_W];
        wait_d[ipos][s] = ins_src_wait[s] &&
                          !(bc_valid && bc_tag == ins_src_tag[s*TAG_W +: TAG_W]);
      end
    end
    cnt_d = cnt_q - CNT_W'(sel_hit) + CNT_W'(ins_fire);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      wait_q[i] <= wait_d[i];
      dst_q[i]  <= dst_d[i];
      hp_q[i]   <= hp_d[i];
      tp_q[i]   <= tp_d[i];
      for (int s = 0; s < NSRC; s++) src_q[i][s] <= src_d[i][s];
    end
    fus_q <= fus_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      tail_pend_q <= 1'b0;
      tail_pay_q  <= '0;
      tail_tag_q  <= '0;
      iss_valid   <= 1'b0;
      iss_second  <= 1'b0;
      iss_pay     <= '0;
      bc_valid    <= 1'b0;
      bc_tag      <= '0;
    end else if (flush) begin
      cnt_q       <= '0;
      tail_pend_q <= 1'b0;
      iss_valid   <= 1'b0;
      iss_second  <= 1'b0;
      bc_valid    <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (tail_pend_q) begin
        iss_valid   <= 1'b1;
        iss_second  <= 1'b1;
        iss_pay     <= tail_pay_q;
        bc_valid    <= 1'b1;
        bc_tag      <= tail_tag_q;
        tail_pend_q <= 1'b0;
      end else if (sel_hit) begin
        iss_valid   <= 1'b1;
        iss_second  <= 1'b0;
        iss_pay     <= hp_q[sel_idx];
        tail_pend_q <= fus_q[sel_idx];
        tail_pay_q  <= tp_q[sel_idx];
        tail_tag_q  <= dst_q[sel_idx];
        bc_valid    <= !fus_q[sel_idx];
        bc_tag      <= dst_q[sel_idx];
      end else begin
        iss_valid  <= 1'b0;
        iss_second <= 1'b0;
        bc_valid   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mop_issue_queue_chk.sv
module mop_issue_queue_chk #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             iss_valid,
  input logic             iss_second,
  input logic             bc_valid,
  input logic [CNT_W-1:0] cnt
);

  p_bcast_rides_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |-> iss_valid);

  p_tail_after_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_second |-> $past(iss_valid && !iss_second));

  p_head_gets_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_second && !bc_valid && !flush) |=> (iss_valid && iss_second));

  p_flush_idles_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!iss_valid && !bc_valid && cnt == '0));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  p_one_insert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= $past(cnt) + CNT_W'(1));

endmodule

bind mop_issue_queue mop_issue_queue_chk #(.DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1))) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .iss_valid(iss_valid),
  .iss_second(iss_second), .bc_valid(bc_valid), .cnt(cnt_q));

// File: tb/test_mop_issue_queue.sv
`timescale 1ns/1ps
module test_mop_issue_queue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic        ins_fused = 1'b0;
  logic [2:0]  ins_src_wait = '0;
  logic [17:0] ins_src_tag = '0;
  logic [5:0]  ins_dst_tag = '0;
  logic [15:0] ins_head_pay = '0;
  logic [15:0] ins_tail_pay = '0;
  logic        iss_valid, iss_second, bc_valid;
  logic [15:0] iss_pay;
  logic [5:0]  bc_tag;

  mop_issue_queue i_mop_issue_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_fused(ins_fused), .ins_src_wait(ins_src_wait), .ins_src_tag(ins_src_tag),
    .ins_dst_tag(ins_dst_tag), .ins_head_pay(ins_head_pay), .ins_tail_pay(ins_tail_pay),
    .iss_valid(iss_valid), .iss_second(iss_second), .iss_pay(iss_pay),
    .bc_valid(bc_valid), .bc_tag(bc_tag));

  always #2 clk = ~clk;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  always @(posedge clk) cyc++;

  int          n_iss = 0, n_bc = 0;
  int          iss_c [256];
  logic [15:0] iss_p [256];
  logic        iss_s [256];
  int          bc_c  [256];
  logic [5:0]  bc_t  [256];

  always @(negedge clk) begin
    if (rst_n) begin
      if (iss_valid && n_iss < 256) begin
        iss_c[n_iss] = cyc; iss_p[n_iss] = iss_pay; iss_s[n_iss] = iss_second; n_iss++;
      end
      if (bc_valid && n_bc < 256) begin
        bc_c[n_bc] = cyc; bc_t[n_bc] = bc_tag; n_bc++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int when_iss(input logic [15:0] p);
    for (int i = 0; i < n_iss; i++) if (iss_p[i] == p) return iss_c[i];
    return -1;
  endfunction

  function automatic int second_of(input logic [15:0] p);
    for (int i = 0; i < n_iss; i++) if (iss_p[i] == p) return int'(iss_s[i]);
    return -1;
  endfunction

  function automatic int when_bc(input logic [5:0] t);
    for (int i = 0; i < n_bc; i++) if (bc_t[i] == t) return bc_c[i];
    return -1;
  endfunction

  function automatic int count_bc(input logic [5:0] t);
    int n = 0;
    for (int i = 0; i < n_bc; i++) if (bc_t[i] == t) n++;
    return n;
  endfunction

  task automatic clr();
    @(negedge clk); #1;
    n_iss = 0; n_bc = 0;
  endtask

  task automatic put(input bit fus, input logic [15:0] h, input logic [15:0] t,
                     input logic [5:0] d, input logic [2:0] w,
                     input logic [5:0] s0, input logic [5:0] s1, input logic [5:0] s2,
                     output int c);
    @(negedge clk);
    ins_valid = 1'b1; ins_fused = fus; ins_head_pay = h; ins_tail_pay = t;
    ins_dst_tag = d; ins_src_wait = w; ins_src_tag = {s2, s1, s0};
    c = cyc;
  endtask

  task automatic idle();
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk(iss_valid == 1'b0, "R1 iss_valid", int'(iss_valid), 0);
    chk(bc_valid == 1'b0, "R1 bc_valid", int'(bc_valid), 0);
    chk(ins_ready == 1'b1, "R1 ins_ready", int'(ins_ready), 1);
  endtask

  task automatic t_basic();
    int c, ti;
    clr();
    put(0, 16'h0101, 16'h0, 6'd1, 3'b000, 0, 0, 0, c);
    idle(); settle(6);
    ti = when_iss(16'h0101);
    chk(ti == c + 2, "R2 issue cycle", ti - c, 2);
    chk(when_bc(6'd1) == ti, "R2 broadcast with issue", when_bc(6'd1), ti);
  endtask

  task automatic t_dep();
    int c0, c1, tp, tc;
    clr();
    put(0, 16'h0201, 16'h0, 6'd2, 3'b000, 0, 0, 0, c0);
    put(0, 16'h0202, 16'h0, 6'd3, 3'b001, 6'd2, 0, 0, c1);
    idle(); settle(8);
    tp = when_iss(16'h0201); tc = when_iss(16'h0202);
    chk(tp >= 0 && tc == tp + 2, "R4 dependent spacing", tc - tp, 2);
  endtask

  task automatic t_fused();
    int c0, c1, th, tt, tc;
    clr();
    put(1, 16'h0301, 16'h0302, 6'd4, 3'b000, 0, 0, 0, c0);
    put(0, 16'h0303, 16'h0, 6'd5, 3'b001, 6'd4, 0, 0, c1);
    idle(); settle(10);
    th = when_iss(16'h0301); tt = when_iss(16'h0302); tc = when_iss(16'h0303);
    chk(th >= 0 && tt == th + 1, "R5 tail follows head", tt - th, 1);
    chk(second_of(16'h0302) == 1, "R5 tail flag", second_of(16'h0302), 1);
    chk(second_of(16'h0301) == 0, "R5 head flag", second_of(16'h0301), 0);
    chk(when_bc(6'd4) == tt, "R5 broadcast with tail", when_bc(6'd4), tt);
    chk(count_bc(6'd4) == 1, "R7 one broadcast per fused unit", count_bc(6'd4), 1);
    chk(tc == tt + 2, "R6 consumer after tail", tc - tt, 2);
  endtask

  task automatic t_busy();
    int c0, c1, th, ts;
    clr();
    put(1, 16'h0401, 16'h0402, 6'd6, 3'b000, 0, 0, 0, c0);
    put(0, 16'h0403, 16'h0, 6'd7, 3'b000, 0, 0, 0, c1);
    idle(); settle(10);
    th = when_iss(16'h0401); ts = when_iss(16'h0403);
    chk(th >= 0 && ts == th + 2, "R9 unit waits behind tail", ts - th, 2);
    chk(n_iss == 3, "R9 issue count", n_iss, 3);
    chk(n_bc == 2, "R7 broadcast count", n_bc, 2);
  endtask

  task automatic t_order();
    int cp, co, cn, tp, to, tn;
    clr();
    put(0, 16'h0501, 16'h0, 6'd8, 3'b000, 0, 0, 0, cp);
    put(0, 16'h0502, 16'h0, 6'd9, 3'b001, 6'd8, 0, 0, co);
    put(0, 16'h0503, 16'h0, 6'd10, 3'b001, 6'd8, 0, 0, cn);
    idle(); settle(10);
    tp = when_iss(16'h0501); to = when_iss(16'h0502); tn = when_iss(16'h0503);
    chk(tp >= 0 && to == tp + 2, "R8 older issues first", to - tp, 2);
    chk(tn == tp + 3, "R13 woken on insert cycle", tn - tp, 3);
  endtask

  task automatic t_three();
    int cq, c1, c2, c3, tq, tp3;
    clr();
    put(0, 16'h0601, 16'h0, 6'd20, 3'b111, 6'd11, 6'd12, 6'd13, cq);
    put(0, 16'h0602, 16'h0, 6'd11, 3'b000, 0, 0, 0, c1);
    put(0, 16'h0603, 16'h0, 6'd12, 3'b000, 0, 0, 0, c2);
    idle(); settle(10);
    chk(when_iss(16'h0601) == -1, "R3 held while a source waits", when_iss(16'h0601), -1);
    put(0, 16'h0604, 16'h0, 6'd13, 3'b000, 0, 0, 0, c3);
    idle(); settle(8);
    tq = when_iss(16'h0601); tp3 = when_iss(16'h0604);
    chk(tp3 >= 0 && tq == tp3 + 2, "R10 third source wakes", tq - tp3, 2);
  endtask

  task automatic t_full();
    int c, rdy;
    clr();
    for (int k = 0; k < 32; k++)
      put(0, 16'h0700 + 16'(k), 16'h0, 6'd30, 3'b001, 6'd40, 0, 0, c);
    put(0, 16'h07FF, 16'h0, 6'd31, 3'b000, 0, 0, 0, c);
    #1;
    rdy = int'(ins_ready);
    chk(rdy == 0, "R11 ready low when full", rdy, 0);
    idle(); settle(6);
    chk(when_iss(16'h07FF) == -1, "R11 dropped insert", when_iss(16'h07FF), -1);
    chk(n_iss == 0, "R11 nothing issued", n_iss, 0);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    #1;
    chk(ins_ready == 1'b1, "R12 flush empties", int'(ins_ready), 1);
    put(0, 16'h0800, 16'h0, 6'd40, 3'b000, 0, 0, 0, c);
    idle(); settle(10);
    chk(n_iss == 1, "R12 flushed entries gone", n_iss, 1);
    chk(when_iss(16'h0800) == c + 2, "R12 queue usable after flush", when_iss(16'h0800) - c, 2);
  endtask

  task automatic t_flush_tail();
    int c;
    clr();
    put(1, 16'h0901, 16'h0902, 6'd41, 3'b000, 0, 0, 0, c);
    idle();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    settle(5);
    chk(when_iss(16'h0901) == c + 2, "R12 head before flush", when_iss(16'h0901) - c, 2);
    chk(when_iss(16'h0902) == -1, "R12 tail abandoned", when_iss(16'h0902), -1);
    chk(count_bc(6'd41) == 0, "R12 no broadcast", count_bc(6'd41), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_dep();
    t_fused();
    t_busy();
    t_order();
    t_three();
    t_full();
    t_flush_tail();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule